// File: doc/BRIEF.md
# Dual-Direction Latched Bus Transceiver

This block links two bidirectional data ports, A and B. Each port is split into independent sections of eight bits. Every section carries two storage paths: one moves data from A toward B and the other from B toward A. Each path has its own active-low enable, active-low latch enable and active-low output enable. Data taken in on one port passes through, or is held in, that path's latch, and appears without inversion on the opposite port through a tri-stated driver.

The block runs on a system clock, so the latches are modelled as clocked registers. A path's latch is open while its enable and its latch enable are both low. While it is open, the latch loads the incoming data at every clock edge. When either control goes high, the latch keeps the value from the last edge at which it was open.

Each pin is modelled as an input, an output and an output-enable bit, so the block can be synthesised. Each pin also has a bus keeper. The keeper tracks the pin whenever something drives it, and it stands in for the pin's value when nothing drives it.

Top module: `bus_latch_xcvr`

## Requirements
- R1: While `rst_n` is low, every bit of `a_oe` and `b_oe` is 0, and all latches and keepers are cleared to zero. A path that is enabled for output after reset, with its latch closed, shows 0.
- R2: With a section's A-to-B enable and latch enable both low, the A-to-B latch is open. After each clock edge, that section's `b_out` equals the A-side data sampled at that edge, without inversion.
- R3: When the latch enable goes high with the enable low, the latch keeps the A data from the last edge at which it was open. Later A changes do not reach `b_out`.
- R4: When the enable goes high, the latch also closes and keeps its last value. Re-enabling with the latch enable high displays that kept value.
- R5: While either the enable or the latch enable of a path is high, that path's latch contents do not change at any clock edge.
- R6: The `b_oe` bits of a section are 1 exactly when that section's A-to-B enable and output enable are both low and reset is released. Otherwise they are 0.
- R7: The B-to-A path behaves as a mirror of the A-to-B path: its latch control, hold and output gate on `a_out`/`a_oe` follow the same rules with the `ba_*` controls and B-side data.
- R8: Sections are independent. A section's controls and data never change another section's latch or outputs.
- R9: Bus hold works per pin through a keeper. A pin is undriven when its external-drive bit (`a_drv`/`b_drv`) is 0 and its own output-enable bit is 0. An undriven pin presents the last value it held while driven, and a latch reads that value.
- R10: A pin driven by this block (its output-enable bit is 1) updates its keeper with the block's own output value. An opposite-direction latch reads that same value.
- R11: If both directions of one section are enabled for output at once, both `a_oe` and `b_oe` of that section are 1. The bench reports this as bus contention.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; latches and keepers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_en_n | input | SECTIONS | A-to-B enable per section, active low |
| ab_le_n | input | SECTIONS | A-to-B latch enable per section, active low |
| ab_oe_n | input | SECTIONS | A-to-B output enable per section, active low |
| ba_en_n | input | SECTIONS | B-to-A enable per section, active low |
| ba_le_n | input | SECTIONS | B-to-A latch enable per section, active low |
| ba_oe_n | input | SECTIONS | B-to-A output enable per section, active low |
| a_in | input | SECTIONS*WIDTH | Value present on the A pins |
| a_drv | input | SECTIONS*WIDTH | 1 where an external driver holds the A pin |
| a_out | output | SECTIONS*WIDTH | B-to-A latch contents driven toward A |
| a_oe | output | SECTIONS*WIDTH | Drive enable for each A pin |
| b_in | input | SECTIONS*WIDTH | Value present on the B pins |
| b_drv | input | SECTIONS*WIDTH | 1 where an external driver holds the B pin |
| b_out | output | SECTIONS*WIDTH | A-to-B latch contents driven toward B |
| b_oe | output | SECTIONS*WIDTH | Drive enable for each B pin |

## Verification
The latch path is tried with a changing stream while open, which shows real transparency rather than a one-time load. Data changes on the same cycle the latch enable rises, or the enable rises, which shows which edge is the last to be captured. Two sections are run side by side, one open and one closed, under a common input change, which separates per-section control from shared control. Floating pins are tested after an external drive and after the block's own drive, which shows whether the keeper tracks both sources. A section with both directions enabled must be reported as contention.

// File: rtl/bus_latch_xcvr.sv
module bus_latch_xcvr #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SECTIONS-1:0]          ab_en_n,
  input  logic [SECTIONS-1:0]          ab_le_n,
  input  logic [SECTIONS-1:0]          ab_oe_n,
  input  logic [SECTIONS-1:0]          ba_en_n,
  input  logic [SECTIONS-1:0]          ba_le_n,
  input  logic [SECTIONS-1:0]          ba_oe_n,
  input  logic [SECTIONS*WIDTH-1:0]    a_in,
  input  logic [SECTIONS*WIDTH-1:0]    a_drv,
  output logic [SECTIONS*WIDTH-1:0]    a_out,
  output logic [SECTIONS*WIDTH-1:0]    a_oe,
  input  logic [SECTIONS*WIDTH-1:0]    b_in,
  input  logic [SECTIONS*WIDTH-1:0]    b_drv,
  output logic [SECTIONS*WIDTH-1:0]    b_out,
  output logic [SECTIONS*WIDTH-1:0]    b_oe
);
  localparam int PINS = SECTIONS * WIDTH;

  logic [PINS-1:0]     a_keep, b_keep;
  logic [PINS-1:0]     a_eff, b_eff;
  logic [SECTIONS-1:0] ab_open, ba_open, ab_drive, ba_drive;

  assign ab_open  = ~(ab_en_n | ab_le_n);
  assign ba_open  = ~(ba_en_n | ba_le_n);
  assign ab_drive = ~(ab_en_n | ab_oe_n) & {SECTIONS{rst_n}};
  assign ba_drive = ~(ba_en_n | ba_oe_n) & {SECTIONS{rst_n}};

  // pin value seen by the block: own drive, then external drive, then keeper
  assign a_eff = (a_oe & a_out) | (~a_oe & a_drv & a_in) | (~a_oe & ~a_drv & a_keep);
  assign b_eff = (b_oe & b_out) | (~b_oe & b_drv & b_in) | (~b_oe & ~b_drv & b_keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_keep <= '0;
      b_keep <= '0;
    end else begin
      a_keep <= a_eff;
      b_keep <= b_eff;
    end
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    logic [WIDTH-1:0] ab_q, ba_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ab_q <= '0;
      else if (ab_open[s])
        ab_q <= a_eff[s*WIDTH +: WIDTH];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ba_q <= '0;
      else if (ba_open[s])
        ba_q <= b_eff[s*WIDTH +: WIDTH];
    end

    assign b_out[s*WIDTH +: WIDTH] = ab_q;
    assign a_out[s*WIDTH +: WIDTH] = ba_q;
    assign b_oe[s*WIDTH +: WIDTH]  = {WIDTH{ab_drive[s]}};
    assign a_oe[s*WIDTH +: WIDTH]  = {WIDTH{ba_drive[s]}};
  end
endmodule

// File: rtl/bus_latch_xcvr_chk.sv
module bus_latch_xcvr_chk #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [SECTIONS-1:0]       ab_en_n,
  input logic [SECTIONS-1:0]       ab_le_n,
  input logic [SECTIONS-1:0]       ab_oe_n,
  input logic [SECTIONS-1:0]       ba_en_n,
  input logic [SECTIONS-1:0]       ba_le_n,
  input logic [SECTIONS-1:0]       ba_oe_n,
  input logic [SECTIONS*WIDTH-1:0] a_in,
  input logic [SECTIONS*WIDTH-1:0] a_drv,
  input logic [SECTIONS*WIDTH-1:0] a_out,
  input logic [SECTIONS*WIDTH-1:0] a_oe,
  input logic [SECTIONS*WIDTH-1:0] b_in,
  input logic [SECTIONS*WIDTH-1:0] b_drv,
  input logic [SECTIONS*WIDTH-1:0] b_out,
  input logic [SECTIONS*WIDTH-1:0] b_oe
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (a_oe == '0 && b_oe == '0));

  for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
    assert_b_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_en_n[s] || ab_oe_n[s]) |-> (b_oe[s*WIDTH +: WIDTH] == '0));

    assert_a_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_en_n[s] || ba_oe_n[s]) |-> (a_oe[s*WIDTH +: WIDTH] == '0));

    assert_ab_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_en_n[s] || ab_le_n[s]) |=> $stable(b_out[s*WIDTH +: WIDTH]));

    assert_ba_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_en_n[s] || ba_le_n[s]) |=> $stable(a_out[s*WIDTH +: WIDTH]));

    assert_ab_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!ab_en_n[s] && !ab_le_n[s] && a_drv[s*WIDTH +: WIDTH] == '1 && a_oe[s*WIDTH +: WIDTH] == '0)
      |=> (b_out[s*WIDTH +: WIDTH] == $past(a_in[s*WIDTH +: WIDTH])));
  end
endmodule

bind bus_latch_xcvr bus_latch_xcvr_chk #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
  .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
  .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/test_bus_latch_xcvr.sv
module test_bus_latch_xcvr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [1:0]  ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;
  logic [15:0] a_in = '0, a_drv = '1, b_in = '0, b_drv = '1;
  logic [15:0] a_out, a_oe, b_out, b_oe;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_latch_xcvr i_bus_latch_xcvr (
    .clk(clk), .rst_n(rst_n),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .a_drv(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_drv(b_drv), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    ab_en_n = '1; ab_le_n = '1; ab_oe_n = '1;
    ba_en_n = '1; ba_le_n = '1; ba_oe_n = '1;
    a_drv = '1; b_drv = '1;
  endtask

  task automatic t_reset();
    tick();
    check("R1 a_oe in reset", a_oe, 16'h0000);
    check("R1 b_oe in reset", b_oe, 16'h0000);
    ab_en_n = '0; ab_oe_n = '0;
    tick();
    check("R1 b_oe held low in reset", b_oe, 16'h0000);
    rst_n = 1;
    tick();
    check("R1 latch zero after reset", b_out, 16'h0000);
    check("R6 b_oe on", b_oe, 16'hFFFF);
    idle();
  endtask

  task automatic t_transparent();
    idle();
    ab_en_n[0] = 0; ab_le_n[0] = 0; ab_oe_n[0] = 0;
    a_in[7:0] = 8'h5A;
    tick();
    check("R2 pass first", {8'h00, b_out[7:0]}, 16'h005A);
    a_in[7:0] = 8'hC3;
    tick();
    check("R2 pass follows", {8'h00, b_out[7:0]}, 16'h00C3);
    check("R6 section0 drive", b_oe, 16'h00FF);
  endtask

  task automatic t_le_capture();
    idle();
    ab_en_n[0] = 0; ab_le_n[0] = 0; ab_oe_n[0] = 0;
    a_in[7:0] = 8'h3C;
    tick();
    ab_le_n[0] = 1; a_in[7:0] = 8'h99;
    tick();
    check("R3 captured on le rise", {8'h00, b_out[7:0]}, 16'h003C);
    a_in[7:0] = 8'h66;
    tick(); tick();
    check("R5 hold while le high", {8'h00, b_out[7:0]}, 16'h003C);
  endtask

  task automatic t_en_capture();
    idle();
    ab_en_n[0] = 0; ab_le_n[0] = 0; ab_oe_n[0] = 0;
    a_in[7:0] = 8'h11;
    tick();
    ab_en_n[0] = 1; a_in[7:0] = 8'h22;
    tick();
    check("R6 off when enable high", b_oe, 16'h0000);
    ab_en_n[0] = 0; ab_le_n[0] = 1;
    tick();
    check("R4 captured on enable rise", {8'h00, b_out[7:0]}, 16'h0011);
    ab_oe_n[0] = 1;
    tick();
    check("R6 off when oe high", b_oe, 16'h0000);
  endtask

  task automatic t_ba();
    idle();
    ba_en_n[1] = 0; ba_le_n[1] = 0; ba_oe_n[1] = 0;
    b_in[15:8] = 8'hA5;
    tick();
    check("R7 B-to-A pass", {a_out[15:8], 8'h00}, 16'hA500);
    check("R7 a_oe section1", a_oe, 16'hFF00);
    ba_le_n[1] = 1; b_in[15:8] = 8'h0F;
    tick();
    check("R7 B-to-A hold", {a_out[15:8], 8'h00}, 16'hA500);
  endtask

  task automatic t_sections();
    logic [7:0] kept;
    idle();
    kept = b_out[15:8];
    ab_en_n[0] = 0; ab_le_n[0] = 0;
    a_in = 16'h7E81;
    tick();
    check("R8 section0 follows", {8'h00, b_out[7:0]}, 16'h0081);
    check("R8 section1 untouched", {b_out[15:8], 8'h00}, {kept, 8'h00});
  endtask

  task automatic t_keeper();
    idle();
    a_in[7:0] = 8'h6E;
    tick();
    a_drv[7:0] = 8'h00; a_in[7:0] = 8'hFF;
    ab_en_n[0] = 0; ab_le_n[0] = 0; ab_oe_n[0] = 0;
    tick();
    check("R9 floating pins read kept value", {8'h00, b_out[7:0]}, 16'h006E);
  endtask

  task automatic t_own_drive();
    idle();
    ba_en_n[1] = 0; ba_le_n[1] = 0; ba_oe_n[1] = 0;
    b_in[15:8] = 8'h47;
    tick(); tick();
    idle();
    a_drv[15:8] = 8'h00; a_in[15:8] = 8'h00;
    ab_en_n[1] = 0; ab_le_n[1] = 0; ab_oe_n[1] = 0;
    tick();
    check("R10 keeper took own drive", {b_out[15:8], 8'h00}, 16'h4700);
  endtask

  task automatic t_contention();
    idle();
    ab_en_n[0] = 0; ab_oe_n[0] = 0;
    ba_en_n[0] = 0; ba_oe_n[0] = 0;
    tick();
    if (a_oe[7:0] != 8'h00 && b_oe[7:0] != 8'h00)
      $display("NOTE R11 bus contention flagged on section 0");
    check("R11 contention both sides", {a_oe[7:0], b_oe[7:0]}, 16'hFFFF);
    idle();
    tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0000, 16'h0001);
    summary();
  end

  initial begin
    t_reset();
    t_transparent();
    t_le_capture();
    t_en_capture();
    t_ba();
    t_sections();
    t_keeper();
    t_own_drive();
    t_contention();
    summary();
  end
endmodule